// File: doc/BRIEF.md
# Registered-Mode Output Macrocell Bank

This block is the output stage of a small programmable AND-OR array while it runs in registered mode. It holds a bank of macrocells. Each macrocell evaluates a group of product terms over the true and complement forms of every array signal. The array signals are the dedicated data inputs plus one feedback signal from each macrocell. A product term can be switched off by its own disable bit. A static configuration vector sets up each macrocell on its own. A macrocell is either a clocked output, whose D flip-flop runs on a shared clock and drives its pin through a shared active-low enable, or a combinatorial I/O, whose pin enable comes from a dedicated product term. A per-cell polarity bit picks an active-high or active-low pin.

The shared clock, shared enable and power-down pins have fixed roles. None of them is ever an array signal. The pin pads are modelled as separate data and enable vectors. The level seen on each pad comes back in on `pin_in`. A small power controller tracks three states. `ST_OFF` means the global mode bits do not select registered mode. `ST_RUN` is normal operation. `ST_SLEEP` is power-down, in which the flip-flops and all pin drives are frozen. The transitions are evaluated on every rising clock edge and do not depend on the current state. Any state goes to `ST_OFF` when the mode is not valid (`cfg_syn`=1 or `cfg_ac0`=0). Any state goes to `ST_SLEEP` when the mode is valid and `pwr_dn`=1. Any state goes to `ST_RUN` when the mode is valid and `pwr_dn`=0. Reset puts the controller in `ST_OFF`.

Top module: `pla_regmode_bank`

## Requirements
- R1: Registered mode is valid only with `cfg_syn`=0 and `cfg_ac0`=1. From the first rising edge that samples an invalid mode, every `pin_oe` bit is 0 and the flip-flops hold their value.
- R2: While `rst_n` is low, all flip-flops are cleared and every `pin_oe` bit is 0, with no clock needed.
- R3: The array signals are S[k]=`din[k]` for k<NUM_IN and S[NUM_IN+c]=`fb[c]`. Literal 2k is S[k] and literal 2k+1 is its complement. Fuse bit ((c*NUM_PT+t)*NUM_LIT+l) set to 1 connects literal l to term t of cell c. A term with no fuse set is 1. A term connected to both forms of one signal is always 0.
- R4: `pt_off[c*NUM_PT+t]`=1 forces term t of cell c to 0.
- R5: A cell with `cfg_ac1`=0 loads the OR of all NUM_PT of its terms into its flip-flop on each rising edge in `ST_RUN`. Its pin shows Q when `cfg_xor`=1 and the inverse of Q when `cfg_xor`=0.
- R6: In `ST_RUN` every registered cell's `pin_oe` equals the inverse of `oe_n`. While `oe_n` is high the flip-flops keep loading.
- R7: A cell with `cfg_ac1`=1 drives the OR of its terms 1 to NUM_PT-1, inverted when `cfg_xor`=0. Its `pin_oe` is term 0. An input-only cell is one whose term 0 is always 0.
- R8: `fb[c]` is the flip-flop state for a registered cell and the pad level `pin_in[c]` for a combinatorial cell.
- R9: Changing `oe_n` has no effect on combinatorial cell pins or on any product term.
- R10: A rising edge that samples valid mode and `pwr_dn`=1 enters `ST_SLEEP`. At that edge the flip-flops do not load. When entered from `ST_RUN`, `pin_out` and `pin_oe` then keep the values they had just before that edge, whatever the inputs do. The first edge that samples `pwr_dn`=0 returns to `ST_RUN` and loads the flip-flops.
- R11: Every cell's `cfg_ac1`/`cfg_xor` choice is independent, so any mix of registered and combinatorial cells works side by side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin for all flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Shared active-low enable for registered pins |
| pwr_dn | input | 1 | Power-down request, sampled on clk |
| din | input | NUM_IN | Dedicated array inputs |
| pin_in | input | NUM_CELLS | Level present on each macrocell pad |
| cfg_syn | input | 1 | Global mode bit, must be 0 |
| cfg_ac0 | input | 1 | Global mode bit, must be 1 |
| cfg_ac1 | input | NUM_CELLS | Per cell: 0 registered, 1 combinatorial I/O |
| cfg_xor | input | NUM_CELLS | Per cell: 1 active high, 0 active low |
| pt_fuse | input | NUM_CELLS*NUM_PT*NUM_LIT | Literal connection bits for every term |
| pt_off | input | NUM_CELLS*NUM_PT | Per-term forced-off bits |
| pin_out | output | NUM_CELLS | Pad drive data |
| pin_oe | output | NUM_CELLS | Pad drive enable |
| fb | output | NUM_CELLS | Feedback returned to the array |

## Verification
A flip-flop that holds a wrong value shows up on its own pin and on `fb` one edge after the bad load. It also spreads into every term that uses that feedback, so a toggling cell and a cell fed from another cell's state bring out errors within two edges. A controller stuck in the wrong state shows at once. In `ST_OFF` no pin is driven. In `ST_SLEEP` the pins stay frozen while the inputs change, and the flip-flops do not advance. A hold register that captured at the wrong time shows as a mismatch in the first cycle after entering power-down.

// File: rtl/pla_regmode_pkg.sv
package pla_regmode_pkg;

    // Power/mode controller states
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/pla_term_array.sv
// Product terms of one macrocell: AND of connected literals, forced off per term.
module pla_term_array #(
    parameter int NUM_LIT = 36,
    parameter int NUM_PT  = 8
) (
    input  logic [NUM_LIT-1:0]        lits,
    input  logic [NUM_PT*NUM_LIT-1:0] fuse,
    input  logic [NUM_PT-1:0]         pt_off,
    output logic [NUM_PT-1:0]         terms
);

    for (genvar t = 0; t < NUM_PT; t++) begin : g_term
        logic [NUM_LIT-1:0] conn;
        assign conn     = fuse[t*NUM_LIT +: NUM_LIT];
        assign terms[t] = ~pt_off[t] & (&(lits | ~conn));
    end

endmodule

// File: rtl/pla_macrocell.sv
// One output macrocell: registered or combinatorial path, polarity, power-down hold.
module pla_macrocell
    import pla_regmode_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pwr_state_e        state,
    input  logic              upd_en,
    input  logic              ac1,
    input  logic              xor_hi,
    input  logic              oe_n,
    input  logic [NUM_PT-1:0] terms,
    output logic              q,
    output logic              pin_out,
    output logic              pin_oe
);

    localparam int OE_TERM = 0;

    logic sum_reg;
    logic sum_comb;
    logic reg_out;
    logic comb_out;
    logic live_out;
    logic live_oe;
    logic hold_out;
    logic hold_oe;

    assign sum_reg  = |terms;
    assign sum_comb = |terms[NUM_PT-1:OE_TERM+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (upd_en) begin
            q <= sum_reg;
        end
    end

    assign reg_out  = xor_hi ? q : ~q;
    assign comb_out = xor_hi ? sum_comb : ~sum_comb;
    assign live_out = ac1 ? comb_out : reg_out;
    assign live_oe  = ac1 ? terms[OE_TERM] : ~oe_n;

    // Snapshot of pin drive, refreshed on every edge outside power-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_out <= 1'b0;
            hold_oe  <= 1'b0;
        end else if (state != ST_SLEEP) begin
            hold_out <= live_out;
            hold_oe  <= live_oe;
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN: begin
                pin_out = live_out;
                pin_oe  = live_oe;
            end
            ST_SLEEP: begin
                pin_out = ac1 ? hold_out : reg_out;
                pin_oe  = hold_oe;
            end
            default: begin
                pin_out = live_out;
                pin_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pla_pwr_ctrl.sv
// Mode and power-down controller shared by all macrocells.
module pla_pwr_ctrl
    import pla_regmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_ok,
    input  logic       pwr_dn,
    output pwr_state_e state,
    output logic       upd_en
);

    pwr_state_e state_q;
    pwr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mode_ok) state_d = pwr_dn ? ST_SLEEP : ST_RUN;
            end
            ST_RUN: begin
                if (!mode_ok)    state_d = ST_OFF;
                else if (pwr_dn) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (!mode_ok)     state_d = ST_OFF;
                else if (!pwr_dn) state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        state  = state_q;
        upd_en = mode_ok & ~pwr_dn;
    end

endmodule

// File: rtl/pla_regmode_bank.sv
// Bank of registered-mode macrocells with shared clock, enable and power-down.
module pla_regmode_bank
    import pla_regmode_pkg::*;
#(
    parameter int NUM_IN    = 10,
    parameter int NUM_CELLS = 8,
    parameter int NUM_PT    = 8,
    localparam int NUM_SIG    = NUM_IN + NUM_CELLS,
    localparam int NUM_LIT    = 2 * NUM_SIG,
    localparam int CELL_FUSES = NUM_PT * NUM_LIT,
    localparam int ALL_FUSES  = NUM_CELLS * CELL_FUSES,
    localparam int ALL_PT     = NUM_CELLS * NUM_PT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 oe_n,
    input  logic                 pwr_dn,
    input  logic [NUM_IN-1:0]    din,
    input  logic [NUM_CELLS-1:0] pin_in,
    input  logic                 cfg_syn,
    input  logic                 cfg_ac0,
    input  logic [NUM_CELLS-1:0] cfg_ac1,
    input  logic [NUM_CELLS-1:0] cfg_xor,
    input  logic [ALL_FUSES-1:0] pt_fuse,
    input  logic [ALL_PT-1:0]    pt_off,
    output logic [NUM_CELLS-1:0] pin_out,
    output logic [NUM_CELLS-1:0] pin_oe,
    output logic [NUM_CELLS-1:0] fb
);

    pwr_state_e           pwr_state;
    logic                 upd_en;
    logic                 mode_ok;
    logic [NUM_CELLS-1:0] q_vec;
    logic [NUM_SIG-1:0]   sig;
    logic [NUM_LIT-1:0]   lits;

    assign mode_ok = ~cfg_syn & cfg_ac0;

    pla_pwr_ctrl u_pwr_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_ok (mode_ok),
        .pwr_dn  (pwr_dn),
        .state   (pwr_state),
        .upd_en  (upd_en)
    );

    // Feedback: flip-flop state or pad level
    assign fb  = (cfg_ac1 & pin_in) | (~cfg_ac1 & q_vec);
    assign sig = {fb, din};

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_lit
        assign lits[2*s]   = sig[s];
        assign lits[2*s+1] = ~sig[s];
    end

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        logic [NUM_PT-1:0] terms;

        pla_term_array #(
            .NUM_LIT (NUM_LIT),
            .NUM_PT  (NUM_PT)
        ) u_terms (
            .lits   (lits),
            .fuse   (pt_fuse[c*CELL_FUSES +: CELL_FUSES]),
            .pt_off (pt_off[c*NUM_PT +: NUM_PT]),
            .terms  (terms)
        );

        pla_macrocell #(
            .NUM_PT (NUM_PT)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .state   (pwr_state),
            .upd_en  (upd_en),
            .ac1     (cfg_ac1[c]),
            .xor_hi  (cfg_xor[c]),
            .oe_n    (oe_n),
            .terms   (terms),
            .q       (q_vec[c]),
            .pin_out (pin_out[c]),
            .pin_oe  (pin_oe[c])
        );
    end

endmodule

// File: rtl/pla_regmode_chk.sv
module pla_regmode_chk
    import pla_regmode_pkg::*;
#(
    parameter int NUM_CELLS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 oe_n,
    input logic                 pwr_dn,
    input logic                 cfg_syn,
    input logic                 cfg_ac0,
    input logic [NUM_CELLS-1:0] cfg_ac1,
    input logic [NUM_CELLS-1:0] pin_in,
    input logic [NUM_CELLS-1:0] pin_out,
    input logic [NUM_CELLS-1:0] pin_oe,
    input logic [NUM_CELLS-1:0] fb,
    input pwr_state_e           state
);

    logic mode_ok;
    assign mode_ok = ~cfg_syn & cfg_ac0;

    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            AST_RESET_NO_DRIVE: assert (pin_oe == '0); // R2
        end
    end

    AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !mode_ok |=> (pin_oe == '0)); // R1

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pwr_dn || !mode_ok) |=> $stable(fb & ~cfg_ac1)); // R10

    AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (mode_ok && pwr_dn && $past(mode_ok && pwr_dn)) |=> ($stable(pin_out) && $stable(pin_oe))); // R10

    AST_SHARED_OE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RUN) |-> ((pin_oe & ~cfg_ac1) == ({NUM_CELLS{~oe_n}} & ~cfg_ac1))); // R6

    AST_COMB_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n) ((fb & cfg_ac1) == (pin_in & cfg_ac1))); // R8

endmodule

bind pla_regmode_bank pla_regmode_chk #(
    .NUM_CELLS (NUM_CELLS)
) u_pla_regmode_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .oe_n    (oe_n),
    .pwr_dn  (pwr_dn),
    .cfg_syn (cfg_syn),
    .cfg_ac0 (cfg_ac0),
    .cfg_ac1 (cfg_ac1),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb      (fb),
    .state   (pwr_state)
);

// File: tb/test_pla_regmode_bank.sv
`timescale 1ns/1ps
module test_pla_regmode_bank;

    localparam int NUM_IN    = 10;
    localparam int NUM_CELLS = 8;
    localparam int NUM_PT    = 8;
    localparam int NUM_LIT   = 2 * (NUM_IN + NUM_CELLS);
    localparam int ALL_FUSES = NUM_CELLS * NUM_PT * NUM_LIT;
    localparam int ALL_PT    = NUM_CELLS * NUM_PT;
    localparam logic [7:0] REG_MASK = 8'b0110_0011; // cells 0,1,5,6 registered
    localparam int NVEC = 8;
    // {oe_n, pin_in[7:0], din[9:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 10'h000},
        {1'b0, 8'h10, 10'h001},
        {1'b0, 8'h00, 10'h0FE},
        {1'b0, 8'h8C, 10'h104},
        {1'b1, 8'h10, 10'h019},
        {1'b1, 8'h00, 10'h060},
        {1'b0, 8'hFF, 10'h3FF},
        {1'b0, 8'h00, 10'h080}
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 oe_n;
    logic                 pwr_dn;
    logic [NUM_IN-1:0]    din;
    logic [NUM_CELLS-1:0] pin_in;
    logic                 cfg_syn;
    logic                 cfg_ac0;
    logic [NUM_CELLS-1:0] cfg_ac1;
    logic [NUM_CELLS-1:0] cfg_xor;
    logic [ALL_FUSES-1:0] pt_fuse;
    logic [ALL_PT-1:0]    pt_off;
    logic [NUM_CELLS-1:0] pin_out;
    logic [NUM_CELLS-1:0] pin_oe;
    logic [NUM_CELLS-1:0] fb;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic [7:0] mq = 8'h00;

    always #2.5 clk = ~clk;

    pla_regmode_bank #(
        .NUM_IN    (NUM_IN),
        .NUM_CELLS (NUM_CELLS),
        .NUM_PT    (NUM_PT)
    ) i_pla_regmode_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_n    (oe_n),
        .pwr_dn  (pwr_dn),
        .din     (din),
        .pin_in  (pin_in),
        .cfg_syn (cfg_syn),
        .cfg_ac0 (cfg_ac0),
        .cfg_ac1 (cfg_ac1),
        .cfg_xor (cfg_xor),
        .pt_fuse (pt_fuse),
        .pt_off  (pt_off),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb      (fb)
    );

    task automatic term_clear(input int c, input int t);
        for (int l = 0; l < NUM_LIT; l++) pt_fuse[(c*NUM_PT+t)*NUM_LIT+l] = 1'b0;
    endtask

    task automatic term_use(input int c, input int t, input int l);
        pt_fuse[(c*NUM_PT+t)*NUM_LIT+l] = 1'b1;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string msg);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", msg, act, exp);
        end
    endtask

    // Reference outputs for the programmed pattern
    function automatic logic [7:0] exp_out();
        return {din[8], mq[6], mq[5], 1'b0, ~(din[5] & din[6]), din[4] | mq[0], ~mq[1], mq[0]};
    endfunction

    function automatic logic [7:0] exp_oe();
        return {1'b1, ~oe_n, ~oe_n, 1'b0, 1'b1, din[3], ~oe_n, ~oe_n};
    endfunction

    function automatic logic [7:0] exp_fb();
        return (mq & REG_MASK) | (pin_in & ~REG_MASK);
    endfunction

    task automatic advance();
        mq[0] = din[0];
        mq[1] = din[1] | din[2];
        mq[5] = pin_in[4];
        mq[6] = ~mq[6];
    endtask

    task automatic step(input logic [18:0] v, input string tag);
        {oe_n, pin_in, din} = v;
        advance();
        @(posedge clk);
        #1;
        chk(pin_out, exp_out(), {"R5/R7/R3/R4 pin_out ", tag});
        chk(pin_oe, exp_oe(), {"R6/R7 pin_oe ", tag});
        chk(fb, exp_fb(), {"R8 fb ", tag});
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap_out;
        logic [7:0] snap_oe;
        rst_n = 1'b0; oe_n = 1'b0; pwr_dn = 1'b0; din = '0; pin_in = '0;
        cfg_syn = 1'b0; cfg_ac0 = 1'b1;
        // R11: mixed bank, cells 0,1,5,6 registered; 2,3,4,7 combinatorial
        cfg_ac1 = 8'b1001_1100;
        cfg_xor = 8'b1111_0101;
        pt_fuse = '1;            // R3: every unused term sees x & ~x, so it is 0
        pt_off  = '0;
        term_clear(0, 0); term_use(0, 0, 0);                      // din0
        term_clear(1, 0); term_use(1, 0, 2);                      // din1
        term_clear(1, 7); term_use(1, 7, 4);                      // din2 on eighth term
        term_clear(2, 0); term_use(2, 0, 6);                      // oe = din3
        term_clear(2, 1); term_use(2, 1, 8);                      // din4
        term_clear(2, 7); term_use(2, 7, 2*NUM_IN);               // fb0
        term_clear(3, 0);                                         // oe always 1
        term_clear(3, 1); term_use(3, 1, 10); term_use(3, 1, 12); // din5 & din6
        term_clear(5, 0); term_use(5, 0, 2*(NUM_IN+4));           // fb4 (pad level)
        term_clear(5, 1); term_use(5, 1, 14);                     // din7, forced off
        pt_off[5*NUM_PT+1] = 1'b1;
        term_clear(6, 0); term_use(6, 0, 2*(NUM_IN+6)+1);         // ~fb6, toggles
        term_clear(7, 0);                                         // oe always 1
        term_clear(7, 1); term_use(7, 1, 16);                     // din8

        repeat (3) @(negedge clk);
        chk(pin_oe, 8'h00, "R2 reset pin_oe");
        chk(fb & REG_MASK, 8'h00, "R2 reset flops");
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i], $sformatf("vec%0d", i));
        end

        // R9: oe_n change mid-cycle leaves combinatorial pins alone
        step({1'b0, 8'h00, 10'h018}, "pre R9");
        oe_n = 1'b1;
        #1;
        chk(pin_out & ~REG_MASK, exp_out() & ~REG_MASK, "R9 comb pin_out with oe_n high");
        chk(pin_oe, exp_oe(), "R9/R6 pin_oe with oe_n high");
        oe_n = 1'b0;

        // R10: power-down entry, hold, and wake
        step({1'b0, 8'h10, 10'h119}, "pre R10");
        snap_out = exp_out();
        snap_oe  = exp_oe();
        pwr_dn = 1'b1;
        @(posedge clk); #1;
        chk(pin_out, snap_out, "R10 entry pin_out");
        chk(pin_oe, snap_oe, "R10 entry pin_oe");
        din = 10'h2E6; pin_in = 8'hEF; oe_n = 1'b1;
        #1;
        chk(pin_out, snap_out, "R10 inputs change pin_out");
        @(posedge clk); #1;
        chk(pin_out, snap_out, "R10 sleep pin_out");
        chk(pin_oe, snap_oe, "R10 sleep pin_oe");
        chk(fb & REG_MASK, mq & REG_MASK, "R10 flops held");
        pwr_dn = 1'b0;
        step({1'b0, 8'h00, 10'h013}, "R10 wake");

        // R1: mode bits not valid
        cfg_ac0 = 1'b0;
        din = 10'h001; pin_in = 8'h10;
        @(posedge clk); #1;
        chk(pin_oe, 8'h00, "R1 ac0=0 pin_oe");
        chk(fb & REG_MASK, mq & REG_MASK, "R1 ac0=0 flops held");
        cfg_ac0 = 1'b1; cfg_syn = 1'b1;
        @(posedge clk); #1;
        chk(pin_oe, 8'h00, "R1 syn=1 pin_oe");
        chk(fb & REG_MASK, mq & REG_MASK, "R1 syn=1 flops held");
        cfg_syn = 1'b0;
        step({1'b0, 8'h10, 10'h0E1}, "R1 mode restored");
        step({1'b0, 8'h00, 10'h004}, "R5 final");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule